// File: doc/BRIEF.md
# Per-Output Request-Queue Grant Scheduler

This block decides which packet buffer an output link sends next. Whenever the
routing logic finds that a packet buffer is bound for this output, it pushes
the buffer's identifier into the block. The identifiers wait in a first-in,
first-out queue. Requests from all inputs share that one queue, so each input
gets a turn in close to arrival order. When the output link is free, the oldest
waiting identifier is granted. If the queue is empty and the link is idle, a
fresh request skips the queue and is granted in the same cycle that it arrives.

A grant stays asserted, with a steady identifier, until the link logic pulses
`done` at the end of the packet. The next waiting request is granted in the
following cycle. The scheduler does not care which input filled a buffer or in
what order. Identifiers from one input may come out in any order, and other
outputs may hold buffers of the same input at the same time. The block places
no condition on whether a packet has been fully received, so a grant may be
issued while the buffer is still filling. A push that meets a full queue with
no pop in that cycle is dropped and reported by a one-cycle error pulse.

Top module: `req_fifo_sched`

## Requirements
- R1: After reset, `grant_valid` and `overflow` are 0 and the queue is empty.
- R2: With no grant held, `out_busy` low and the queue empty, a push raises `grant_valid` in the same cycle with `grant_id` equal to `push_id`.
- R3: Queued identifiers are granted in the order they were pushed, whatever their values.
- R4: Once raised, `grant_valid` stays high and `grant_id` stays unchanged until a cycle in which `done` is 1.
- R5: In the cycle after a `done` pulse that ends a grant, if a request is waiting and `out_busy` is low, the next identifier is granted.
- R6: While no grant is held and `out_busy` is 1, `grant_valid` stays 0 and waiting requests remain queued.
- R7: A push and a grant from the queue in the same cycle are both accepted, including when the queue is full; `overflow` stays 0.
- R8: A push while the queue holds DEPTH entries and nothing is granted from it raises `overflow` for exactly one cycle, in the next cycle. The pushed identifier is discarded.
- R9: A `done` pulse while no grant is held has no effect.
- R10: Pushes arriving while a grant is held do not change `grant_id`; they are queued behind the waiting entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Request for this output is present |
| push_id | input | ID_W | Buffer identifier of the request |
| out_busy | input | 1 | Output link cannot start a new packet |
| done | input | 1 | Pulse: the granted packet has been sent |
| grant_valid | output | 1 | A buffer is granted to the output |
| grant_id | output | ID_W | Identifier of the granted buffer |
| overflow | output | 1 | One-cycle pulse: a push was dropped on a full queue |

## Verification
The bench builds the scheduler with its default values, 4-bit identifiers and a 16-entry queue. At these values the queue fills after sixteen pushes, so the full-queue cases are cheap to reach. These cases are a dropped push, and a push and a pop in one cycle while full. Every identifier value fits in the drained sequence. The small identifier space also lets the bench use non-monotonic and repeated identifiers, which shows that the order comes from the queue and not from the values.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  // Grant controller state: either waiting to issue, or holding a grant.
  typedef enum logic [0:0] {
    GS_IDLE = 1'b0,
    GS_HOLD = 1'b1
  } grant_state_e;

endpackage

// File: rtl/rfs_queue.sv
module rfs_queue #(
  parameter int ID_W  = 4,
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [ID_W-1:0] wr_id,
  input  logic            rd_en,
  output logic [ID_W-1:0] head_id,
  output logic            empty,
  output logic            full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ID_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  // Storage without reset so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_id;
  end

  assign head_id = mem[rd_ptr];
  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
      if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
      case ({wr_en, rd_en})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/rfs_grant_ctl.sv
module rfs_grant_ctl
  import rfs_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_valid,
  input  logic [ID_W-1:0] push_id,
  input  logic            out_busy,
  input  logic            done,
  input  logic            q_empty,
  input  logic            q_full,
  input  logic [ID_W-1:0] q_head,
  output logic            q_wr,
  output logic            q_rd,
  output logic            holding,
  output logic            grant_valid,
  output logic [ID_W-1:0] grant_id,
  output logic            overflow
);

  grant_state_e    state_q;
  logic [ID_W-1:0] held_id_q;
  logic            ovf_q;
  logic            issue;
  logic            bypass;
  logic [ID_W-1:0] issue_id;

  assign holding  = (state_q == GS_HOLD);
  assign issue    = !holding && !out_busy && (!q_empty || push_valid);
  assign bypass   = issue && q_empty;
  assign issue_id = q_empty ? push_id : q_head;

  assign q_rd = issue && !q_empty;
  assign q_wr = push_valid && !bypass && (!q_full || q_rd);

  assign grant_valid = holding || issue;
  assign grant_id    = holding ? held_id_q : issue_id;
  assign overflow    = ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= GS_IDLE;
      held_id_q <= '0;
      ovf_q     <= 1'b0;
    end else begin
      ovf_q <= push_valid && !bypass && q_full && !q_rd;
      if (holding) begin
        if (done) state_q <= GS_IDLE;
      end else if (issue) begin
        state_q   <= GS_HOLD;
        held_id_q <= issue_id;
      end
    end
  end

endmodule

// File: rtl/req_fifo_sched.sv
module req_fifo_sched #(
  parameter int ID_W  = 4,
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_valid,
  input  logic [ID_W-1:0] push_id,
  input  logic            out_busy,
  input  logic            done,
  output logic            grant_valid,
  output logic [ID_W-1:0] grant_id,
  output logic            overflow
);

  logic            q_wr, q_rd, q_empty, q_full, holding;
  logic [ID_W-1:0] q_head;

  rfs_queue #(.ID_W(ID_W), .DEPTH(DEPTH)) u_queue (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (q_wr),
    .wr_id   (push_id),
    .rd_en   (q_rd),
    .head_id (q_head),
    .empty   (q_empty),
    .full    (q_full)
  );

  rfs_grant_ctl #(.ID_W(ID_W)) u_ctl (
    .clk         (clk),
    .rst         (rst),
    .push_valid  (push_valid),
    .push_id     (push_id),
    .out_busy    (out_busy),
    .done        (done),
    .q_empty     (q_empty),
    .q_full      (q_full),
    .q_head      (q_head),
    .q_wr        (q_wr),
    .q_rd        (q_rd),
    .holding     (holding),
    .grant_valid (grant_valid),
    .grant_id    (grant_id),
    .overflow    (overflow)
  );

endmodule

// File: rtl/req_fifo_sched_chk.sv
module req_fifo_sched_chk #(
  parameter int ID_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            push_valid,
  input logic [ID_W-1:0] push_id,
  input logic            out_busy,
  input logic            done,
  input logic            grant_valid,
  input logic [ID_W-1:0] grant_id,
  input logic            overflow,
  input logic            q_empty,
  input logic            q_full,
  input logic            holding
);

  assert_bypass_R2: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !out_busy && q_empty && !holding)
      |-> (grant_valid && grant_id == push_id));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && !done) |=> (grant_valid && $stable(grant_id)));

  assert_next_head_R5: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && done && !q_empty) ##1 !out_busy |-> grant_valid);

  assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    (out_busy && !holding) |-> !grant_valid);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !q_full) |=> !overflow);

  assert_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (push_valid && q_full && (out_busy || holding)) |=> overflow);

  assert_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    overflow |=> !overflow || $past(push_valid && q_full));

endmodule

bind req_fifo_sched req_fifo_sched_chk #(.ID_W(ID_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .push_valid  (push_valid),
  .push_id     (push_id),
  .out_busy    (out_busy),
  .done        (done),
  .grant_valid (grant_valid),
  .grant_id    (grant_id),
  .overflow    (overflow),
  .q_empty     (q_empty),
  .q_full      (q_full),
  .holding     (holding)
);

// File: tb/req_fifo_sched_test.sv
`timescale 1ns/1ps
module req_fifo_sched_test;

  localparam int ID_W  = 4;
  localparam int DEPTH = 16;
  localparam int NVEC  = 19;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            push_valid = 1'b0;
  logic [ID_W-1:0] push_id = '0;
  logic            out_busy = 1'b0;
  logic            done = 1'b0;
  logic            grant_valid;
  logic [ID_W-1:0] grant_id;
  logic            overflow;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  req_fifo_sched #(.ID_W(ID_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_id(push_id),
    .out_busy(out_busy), .done(done), .grant_valid(grant_valid),
    .grant_id(grant_id), .overflow(overflow)
  );

  // {push_v, push_id, busy, done, exp_gv, exp_gid, exp_ovf}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},  // idle, R1
    {1'b1, 4'd5, 1'b0, 1'b0, 1'b1, 4'd5, 1'b0},  // bypass R2
    {1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 4'd5, 1'b0},  // held R4
    {1'b1, 4'd9, 1'b0, 1'b0, 1'b1, 4'd5, 1'b0},  // push under grant R10
    {1'b1, 4'd2, 1'b0, 1'b0, 1'b1, 4'd5, 1'b0},  // R10
    {1'b0, 4'd0, 1'b0, 1'b1, 1'b1, 4'd5, 1'b0},  // done
    {1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 4'd9, 1'b0},  // next head R5
    {1'b1, 4'd7, 1'b0, 1'b1, 1'b1, 4'd9, 1'b0},  // done + push
    {1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0},  // busy R6
    {1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0},  // busy R6
    {1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 4'd2, 1'b0},  // order R3
    {1'b0, 4'd0, 1'b0, 1'b1, 1'b1, 4'd2, 1'b0},
    {1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 4'd7, 1'b0},  // order R3
    {1'b0, 4'd0, 1'b0, 1'b1, 1'b1, 4'd7, 1'b0},
    {1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},  // empty
    {1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0},  // stray done R9
    {1'b1, 4'd3, 1'b0, 1'b0, 1'b1, 4'd3, 1'b0},  // R9 no effect
    {1'b0, 4'd0, 1'b0, 1'b1, 1'b1, 4'd3, 1'b0},
    {1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0}
  };

  task automatic check(input string req, input logic [ID_W+1:0] got,
                       input logic [ID_W+1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got gv/gid/ovf=%b expected %b at t=%0t",
               req, got, exp, $time);
    end
  endtask

  // Compare outputs; grant_id only when a grant is expected.
  task automatic expect_out(input string req, input logic gv,
                            input logic [ID_W-1:0] gid, input logic ovf);
    logic [ID_W-1:0] g;
    g = gv ? grant_id : '0;
    check(req, {grant_valid, g, overflow}, {gv, (gv ? gid : 4'd0), ovf});
  endtask

  task automatic drive(input logic pv, input logic [ID_W-1:0] id,
                       input logic bz, input logic dn);
    @(posedge clk);
    #1;
    push_valid = pv; push_id = id; out_busy = bz; done = dn;
    @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    expect_out("R1", 1'b0, '0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][12], VEC[i][11:8], VEC[i][7], VEC[i][6]);
      expect_out($sformatf("vec%0d R2-R6 R9 R10", i),
                 VEC[i][5], VEC[i][4:1], VEC[i][0]);
    end

    // Fill the queue with the link busy: ids 0..15.
    for (int i = 0; i < DEPTH; i++) begin
      drive(1'b1, ID_W'(i), 1'b1, 1'b0);
      expect_out("R6 fill", 1'b0, '0, 1'b0);
    end
    // Push on full without pop: dropped, overflow next cycle.
    drive(1'b1, 4'd15, 1'b1, 1'b0);
    expect_out("R8 same cycle", 1'b0, '0, 1'b0);
    drive(1'b0, '0, 1'b1, 1'b0);
    expect_out("R8 pulse", 1'b0, '0, 1'b1);
    drive(1'b0, '0, 1'b1, 1'b0);
    expect_out("R8 one cycle", 1'b0, '0, 1'b0);
    // Full: push and pop together.
    drive(1'b1, 4'd10, 1'b0, 1'b0);
    expect_out("R7 pop head", 1'b1, 4'd0, 1'b0);
    drive(1'b0, '0, 1'b0, 1'b1);
    expect_out("R7 no overflow", 1'b1, 4'd0, 1'b0);
    // Drain: 1..15 then 10 (the overflowed id is gone).
    for (int k = 1; k <= DEPTH; k++) begin
      logic [ID_W-1:0] e;
      e = (k == DEPTH) ? 4'd10 : ID_W'(k);
      drive(1'b0, '0, 1'b0, 1'b0);
      expect_out("R3 R7 R8 drain", 1'b1, e, 1'b0);
      drive(1'b0, '0, 1'b0, 1'b1);
    end
    drive(1'b0, '0, 1'b0, 1'b0);
    expect_out("R3 drained", 1'b0, '0, 1'b0);

    // Reset while a grant is held and entries wait.
    drive(1'b1, 4'd6, 1'b0, 1'b0);
    drive(1'b1, 4'd8, 1'b0, 1'b0);
    @(posedge clk);
    #1 rst = 1'b1; push_valid = 1'b0;
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    expect_out("R1 reset", 1'b0, '0, 1'b0);
    drive(1'b0, '0, 1'b0, 1'b0);
    expect_out("R1 queue empty", 1'b0, '0, 1'b0);
    drive(1'b1, 4'd12, 1'b0, 1'b0);
    expect_out("R1 R2 after reset", 1'b1, 4'd12, 1'b0);
    drive(1'b0, '0, 1'b0, 1'b1);

    report();
  end

endmodule